// File: doc/BRIEF.md
# Receive FIFO with programmable trigger level

This block sits behind a serial receiver and holds incoming bytes until a bus master collects them. Bytes arrive on a one-cycle valid strobe and go into a 16-entry circular store. The master sees the oldest byte on the read data output whenever the store is not empty. It takes that byte by pulsing the read strobe for one cycle.

The block keeps an occupancy count and compares it with a trigger level picked by a 2-bit code. It drives a "enough data" flag and a receive interrupt request from that comparison. The flag and interrupt move only on queue events: a push can raise them and a pop can drop them. A synchronous clear empties the store in one cycle.

The input side has no back-pressure. The receiver does not wait on the block. A byte offered while the store is full, or while the receiver enable is low, is lost, and nothing records the loss. The read side needs no handshake either: a strobe on an empty store simply has no effect.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the count is 0, the flag and the interrupt are low, and the read data output shows 8'hFF.
- R2: A byte with in_valid high, rx_en high and count below 16 is stored at the next clock edge, and the count rises by one.
- R3: A byte offered when the count is 16 and no pop happens in the same cycle is dropped. The count stays 16 and the stored bytes are unchanged.
- R4: While rx_en is low, in_valid has no effect on the count, the flag or the contents.
- R5: While the count is nonzero, rd_data shows the oldest stored byte, and the bytes come out in arrival order across pointer wrap. A cycle with rd_req high removes that byte and lowers the count by one.
- R6: With a count of 0, rd_data is 8'hFF and rd_req changes nothing.
- R7: trig_sel codes map to trigger levels as follows: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R8: The flag sets after a push that leaves the count at or above the trigger. It clears after a pop that leaves the count below it. A change of trig_sel alone does not move the flag.
- R9: A push and a pop in the same cycle leave the count unchanged, and the flag becomes (count >= trigger).
- R10: The interrupt sets after a push that leaves the count at or above the trigger, provided irq_en is high. It drops in any cycle after irq_en is low, after a clear, or when the flag clears.
- R11: clr zeroes the count and both pointers and lowers the flag and the interrupt at the next edge. A push or pop in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; bytes are accepted only while high |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| rd_req | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte, or 8'hFF when empty |
| trig_sel | input | 2 | Trigger level code |
| clr | input | 1 | Synchronous clear of the store |
| irq_en | input | 1 | Receive interrupt enable |
| count | output | 5 | Bytes held, 0 to 16 |
| full_flag | output | 1 | Count reached trigger |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench fills and drains the store under every trigger code and checks the flag edge at the exact count where it should move. A wrong level decode or an off-by-one comparison would move the flag one byte early or late. It pushes into a full store and pops from an empty one. A design that wrapped the count would show 0 or 31, and one that corrupted a pointer would return bytes out of order on the later drain. Same-cycle push and pop, a clear that collides with traffic, and trigger changes without traffic are driven deliberately. A design that evaluated the flag on the wrong count, let traffic win over a clear, or re-evaluated the flag on every cycle would diverge from the bench's model there.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Trigger level for each 2-bit select code.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign push_ok = push_req && !clr && (count != FULL);
  assign pop_ok  = pop_req && !clr && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && push_req && !pop_req && !clr) |=> count == FULL);
  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req && !push_req && !clr) |=> (count == '0 && $stable(rd_ptr)));
  assert_clr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(i)) cells[i] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  input  logic          irq_en,
  output logic          flag,
  output logic          irq
);
  logic [CW-1:0] cnt_nxt;
  logic          set_ev;
  logic          flag_d;
  logic          irq_d;

  always_comb begin
    cnt_nxt = count;
    if (push_ok && !pop_ok) cnt_nxt = count + 1'b1;
    if (pop_ok && !push_ok) cnt_nxt = count - 1'b1;
    set_ev = push_ok && (cnt_nxt >= trig);

    flag_d = flag;
    if (clr)                      flag_d = 1'b0;
    else if (push_ok && pop_ok)   flag_d = (count >= trig);
    else if (set_ev)              flag_d = 1'b1;
    else if (pop_ok && cnt_nxt < trig) flag_d = 1'b0;

    irq_d = irq;
    if (clr || !irq_en) irq_d = 1'b0;
    else if (set_ev)    irq_d = 1'b1;
    else if (!flag_d)   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= irq_d;
    end
  end

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(push_ok));
  assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(pop_ok || clr));
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
  assert_irq_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!irq && !flag));
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    trig_sel,
  input  logic          clr,
  input  logic          irq_en,
  output logic [CW-1:0] count,
  output logic          full_flag,
  output logic          irq
);
  import rxf_pkg::*;

  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] head_byte;
  logic [CW-1:0] trig;

  assign trig = CW'(trig_level(trig_sel));

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(in_valid && rx_en), .pop_req(rd_req),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(head_byte)
  );

  rxf_thresh #(.CW(CW)) u_thresh (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_ok(push_ok), .pop_ok(pop_ok), .count(count), .trig(trig),
    .irq_en(irq_en), .flag(full_flag), .irq(irq)
  );

  assign rd_data = (count != '0) ? head_byte : '1;

  assert_rxen_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_req && !clr) |=> $stable(count));
endmodule

// File: tb/sim_rx_trig_fifo.sv
`timescale 1ns/100ps
module sim_rx_trig_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, in_valid = 1'b0, rd_req = 1'b0, clr = 1'b0, irq_en = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] trig_sel = '0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic full_flag, irq;

  always #2.5 clk = ~clk;

  rx_trig_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
    .rd_req(rd_req), .rd_data(rd_data), .trig_sel(trig_sel), .clr(clr),
    .irq_en(irq_en), .count(count), .full_flag(full_flag), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mq [16];
  int mh = 0, mt = 0, mc = 0;
  bit mf = 0, mi = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lvl(int s);
    return (s == 0) ? 1 : (s == 3) ? 14 : 4 * s;
  endfunction

  // One clock step; called at a negedge.
  task automatic step(string tag, bit v, logic [7:0] d, bit en, bit rd,
                      int s, bit c, bit ien);
    bit pu, po, setev;
    int nc, tl;
    in_valid = v; in_data = d; rx_en = en; rd_req = rd;
    trig_sel = 2'(s); clr = c; irq_en = ien;
    #0.5;
    chk(tag, "rd_data", rd_data, (mc > 0) ? mq[mt] : 8'hFF);
    @(posedge clk);
    tl = lvl(s);
    pu = v && en && !c && mc < 16;
    po = rd && !c && mc > 0;
    if (c) begin
      mc = 0; mh = 0; mt = 0; mf = 0; mi = 0;
    end else begin
      if (pu) begin mq[mh] = d; mh = (mh + 1) % 16; end
      if (po) mt = (mt + 1) % 16;
      nc = mc + int'(pu) - int'(po);
      setev = pu && nc >= tl;
      if (pu && po) mf = (mc >= tl);
      else if (setev) mf = 1;
      else if (po && nc < tl) mf = 0;
      if (!ien) mi = 0;
      else if (setev) mi = 1;
      else if (!mf) mi = 0;
      mc = nc;
    end
    @(negedge clk);
    chk(tag, "count", count, mc);
    chk(tag, "flag", full_flag, mf);
    chk(tag, "irq", irq, mi);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count", count, 0);
    chk("R1", "flag", full_flag, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "rd_data", rd_data, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep all trigger codes: fill past full, then drain past empty.
    for (int s = 0; s < 4; s++) begin
      step("R11", 0, 0, 1, 0, s, 1, 1);
      for (int i = 0; i < 16; i++) step("R7", 1, 8'(s * 40 + i), 1, 0, s, 0, 1);
      step("R3", 1, 8'hAA, 1, 0, s, 0, 1);
      step("R3", 1, 8'hBB, 1, 0, s, 0, 1);
      for (int i = 0; i < 16; i++) step("R5", 0, 0, 1, 1, s, 0, 1);
      step("R6", 0, 0, 1, 1, s, 0, 1);
      step("R8", 0, 0, 1, 0, s, 0, 1);
    end

    // Wrap: offset pointers then cycle through.
    for (int i = 0; i < 5; i++) step("R2", 1, 8'(100 + i), 1, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R5", 0, 0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 14; i++) step("R5", 1, 8'(i * 7), 1, 0, 1, 0, 0);

    // Receiver disabled.
    for (int i = 0; i < 4; i++) step("R4", 1, 8'h55, 0, 0, 1, 0, 1);

    // Trigger change without traffic, then a push.
    step("R8", 0, 0, 1, 0, 3, 0, 1);
    step("R8", 0, 0, 1, 0, 0, 0, 1);
    step("R10", 1, 8'h11, 1, 0, 3, 0, 1);
    step("R10", 0, 0, 1, 0, 3, 0, 0);
    step("R10", 0, 0, 1, 0, 3, 0, 1);
    step("R10", 1, 8'h12, 1, 0, 3, 0, 1);
    step("R10", 0, 0, 1, 1, 3, 0, 1);

    // Simultaneous push and pop around trigger boundaries.
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 4; i++) step("R9", 1, 8'(i + 60), 1, 1, s, 0, 1);
    step("R9", 1, 8'h77, 1, 1, 2, 0, 1);

    // Full plus push plus pop.
    while (mc < 16) step("R3", 1, 8'h33, 1, 0, 2, 0, 1);
    step("R3", 1, 8'h44, 1, 1, 2, 0, 1);

    // Clear colliding with traffic.
    step("R11", 1, 8'h99, 1, 1, 2, 1, 1);
    step("R11", 1, 8'h9A, 1, 1, 2, 1, 1);
    step("R6", 0, 0, 1, 1, 2, 0, 1);

    // Mixed traffic.
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step("R2", r < 55, 8'($urandom), r % 9 != 0, (r % 3) == 0,
           int'($urandom_range(0, 3)) , r == 97, r % 11 != 0);
    end
    while (mc > 0) step("R5", 0, 0, 1, 1, 0, 0, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule